// File: doc/BRIEF.md
# Loop-Indexed Operand Address Generator

This block turns the integer part of a 64-bit vector floating-point instruction into the four register-file addresses that the floating-point operation needs: one destination and three sources. The instruction carries four 16-bit sub-operations, one per lane. Lane 0 yields the destination index, and lanes 1, 2 and 3 yield the indices of sources A, B and C. Each lane reads its own byte lane of a 16-entry, four-lane, 8-bit integer register file and applies one of four exact integer operations. A loop body can therefore address `reg[i + k]` for every operand without issuing separate index instructions.

Each lane also carries a 2-bit target-file code. The code selects how deep the addressed file is. A result that does not fit that depth is wrapped modulo the depth and flagged. The indices, the file codes and the flags appear one cycle after the instruction is presented. An integer register write in the same cycle is forwarded to the calculation, so a loop counter can be stepped and used in the same cycle.

Top module: `idx_calc_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs become zero after that edge: `out_valid`, `out_idx`, `out_sel` and `out_oor`. The same edge clears all 16 integer registers to zero.
- R2: `out_valid` is high for exactly the cycle after an edge at which `in_valid` was high. `out_idx`, `out_sel` and `out_oor` keep their values after an edge at which `in_valid` was low.
- R3: Lane L's sub-operation is `in_subops[16L+15:16L]`, split as op `[15:14]`, ra `[13:10]`, rb `[9:6]` and imm `[5:0]`. Lane L reads byte L (`[8L+7:8L]`) of each register. Lane 0 feeds the destination and lanes 1 to 3 feed sources A to C. Op 0 passes the value of register ra.
- R4: Op 1 adds the zero-extended 6-bit imm to register ra.
- R5: Op 2 adds register ra and register rb as a 9-bit sum, with no truncation.
- R6: Op 3 computes ra times rb plus imm as an exact 17-bit integer, and the range check uses that full result.
- R7: `wr_en` writes all four bytes of `wr_data` into register `wr_addr`. Later reads return the value last written.
- R8: The lane 0 code uses only bit 0: 0 selects the general file (depth 32) and 1 selects the output file (depth 16). For lanes 1 to 3, code 0 selects the general file (32), code 1 the input file (32), and code 2 or 3 the constant memory (256). `out_sel` returns `in_sel` registered.
- R9: When a lane's full result is greater than or equal to the selected depth, its `out_oor` bit is set and its index is the result modulo the depth. Otherwise the bit is clear and the index equals the result.
- R10: A register write in the same cycle as an accepted instruction is seen by that instruction's reads of that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_subops | input | 64 | Four 16-bit lane sub-operations |
| in_sel | input | 8 | Four 2-bit target-file codes |
| wr_en | input | 1 | Integer register write enable |
| wr_addr | input | 4 | Integer register write address |
| wr_data | input | 32 | Four-byte write data |
| out_valid | output | 1 | Indices valid |
| out_idx | output | 32 | Four 8-bit indices, lane 0 destination |
| out_sel | output | 8 | Registered target-file codes |
| out_oor | output | 4 | Per-lane out-of-range flags |

## Verification
The directed patterns each isolate one behaviour:
- Distinct byte values per lane expose any lane that reads the wrong byte.
- Sums that land exactly on 16, 32 and 256 separate a correct range test from an off-by-one.
- A multiply whose product overflows 8 bits shows whether the full 17-bit result reaches the range check.
- A loop that steps the counter register in the same cycle that it is used separates forwarding from a stale read.
- Setting bit 1 of the lane 0 code checks that the bit is ignored.

A long stretch of random instructions mixed with writes is then compared against a behavioural model on every cycle.

// File: rtl/idx_calc_pkg.sv
package idx_calc_pkg;

    localparam int LANES    = 4;
    localparam int LANE_W   = 8;
    localparam int NREG     = 16;
    localparam int RADDR_W  = $clog2(NREG);
    localparam int IMM_W    = 6;
    localparam int OP_W     = 2;
    localparam int FIELD_W  = OP_W + 2 * RADDR_W + IMM_W;
    localparam int SEL_W    = 2;
    localparam int RES_W    = 2 * LANE_W + 1;
    localparam int WORD_W   = LANES * LANE_W;

    localparam int GPR_LG   = 5;
    localparam int VIN_LG   = 5;
    localparam int CONST_LG = 8;
    localparam int VOUT_LG  = 4;

    typedef enum logic [OP_W-1:0] {
        OP_PASS = 2'd0,
        OP_ADDI = 2'd1,
        OP_ADDR = 2'd2,
        OP_MADD = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        F_GPR   = 2'd0,
        F_VIN   = 2'd1,
        F_CONST = 2'd2,
        F_VOUT  = 2'd3
    } file_e;

    typedef struct packed {
        op_e                op;
        logic [RADDR_W-1:0] ra;
        logic [RADDR_W-1:0] rb;
        logic [IMM_W-1:0]   imm;
    } subop_t;

    typedef struct packed {
        logic [LANE_W-1:0] idx;
        logic              oor;
    } lane_res_t;

    function automatic file_e map_file(input int lane, input logic [SEL_W-1:0] code);
        if (lane == 0) return code[0] ? F_VOUT : F_GPR;
        case (code)
            2'd0:    return F_GPR;
            2'd1:    return F_VIN;
            default: return F_CONST;
        endcase
    endfunction

    function automatic int depth_lg(input file_e f);
        case (f)
            F_GPR:   return GPR_LG;
            F_VIN:   return VIN_LG;
            F_CONST: return CONST_LG;
            default: return VOUT_LG;
        endcase
    endfunction

endpackage

// File: rtl/idx_regfile.sv
module idx_regfile
    import idx_calc_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           we,
    input  logic [RADDR_W-1:0]             waddr,
    input  logic [WORD_W-1:0]              wdata,
    input  logic [LANES-1:0][RADDR_W-1:0]  ra_addr,
    input  logic [LANES-1:0][RADDR_W-1:0]  rb_addr,
    output logic [LANES-1:0][LANE_W-1:0]   ra_data,
    output logic [LANES-1:0][LANE_W-1:0]   rb_data
);

    logic [WORD_W-1:0] mem [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < NREG; r++) mem[r] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_rd
        always_comb begin
            if (we && waddr == ra_addr[l])
                ra_data[l] = wdata[l*LANE_W +: LANE_W];
            else
                ra_data[l] = mem[ra_addr[l]][l*LANE_W +: LANE_W];
            if (we && waddr == rb_addr[l])
                rb_data[l] = wdata[l*LANE_W +: LANE_W];
            else
                rb_data[l] = mem[rb_addr[l]][l*LANE_W +: LANE_W];
        end
    end

endmodule

// File: rtl/idx_lane.sv
module idx_lane
    import idx_calc_pkg::*;
#(
    parameter int LANE_ID = 0
) (
    input  subop_t            sop,
    input  logic [LANE_W-1:0] a,
    input  logic [LANE_W-1:0] b,
    input  logic [SEL_W-1:0]  code,
    output lane_res_t         res
);

    logic [RES_W-1:0] full;
    logic [RES_W-1:0] mask;
    file_e            tgt;
    int               lg;

    always_comb begin
        case (sop.op)
            OP_PASS: full = RES_W'(a);
            OP_ADDI: full = RES_W'(a) + RES_W'(sop.imm);
            OP_ADDR: full = RES_W'(a) + RES_W'(b);
            default: full = RES_W'(a) * RES_W'(b) + RES_W'(sop.imm);
        endcase
        tgt     = map_file(LANE_ID, code);
        lg      = depth_lg(tgt);
        mask    = (RES_W'(1) << lg) - RES_W'(1);
        res.oor = (full & ~mask) != '0;
        res.idx = LANE_W'(full & mask);
    end

endmodule

// File: rtl/idx_calc_unit.sv
module idx_calc_unit
    import idx_calc_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic [LANES*FIELD_W-1:0]   in_subops,
    input  logic [LANES*SEL_W-1:0]     in_sel,
    input  logic                       wr_en,
    input  logic [RADDR_W-1:0]         wr_addr,
    input  logic [WORD_W-1:0]          wr_data,
    output logic                       out_valid,
    output logic [WORD_W-1:0]          out_idx,
    output logic [LANES*SEL_W-1:0]     out_sel,
    output logic [LANES-1:0]           out_oor
);

    subop_t                          sop   [LANES];
    lane_res_t                       res   [LANES];
    logic [LANES-1:0][RADDR_W-1:0]   ra_addr;
    logic [LANES-1:0][RADDR_W-1:0]   rb_addr;
    logic [LANES-1:0][LANE_W-1:0]    ra_data;
    logic [LANES-1:0][LANE_W-1:0]    rb_data;
    logic [WORD_W-1:0]               idx_next;
    logic [LANES-1:0]                oor_next;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign sop[l]     = subop_t'(in_subops[l*FIELD_W +: FIELD_W]);
        assign ra_addr[l] = sop[l].ra;
        assign rb_addr[l] = sop[l].rb;

        idx_lane #(.LANE_ID(l)) u_lane (
            .sop  (sop[l]),
            .a    (ra_data[l]),
            .b    (rb_data[l]),
            .code (in_sel[l*SEL_W +: SEL_W]),
            .res  (res[l])
        );

        assign idx_next[l*LANE_W +: LANE_W] = res[l].idx;
        assign oor_next[l]                  = res[l].oor;
    end

    idx_regfile u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (wr_en),
        .waddr   (wr_addr),
        .wdata   (wr_data),
        .ra_addr (ra_addr),
        .rb_addr (rb_addr),
        .ra_data (ra_data),
        .rb_data (rb_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_idx   <= '0;
            out_sel   <= '0;
            out_oor   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_idx <= idx_next;
                out_sel <= in_sel;
                out_oor <= oor_next;
            end
        end
    end

endmodule

// File: rtl/idx_calc_chk.sv
module idx_calc_chk
    import idx_calc_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     in_valid,
    input logic [LANES*FIELD_W-1:0] in_subops,
    input logic [LANES*SEL_W-1:0]   in_sel,
    input logic                     wr_en,
    input logic [RADDR_W-1:0]       wr_addr,
    input logic [WORD_W-1:0]        wr_data,
    input logic                     out_valid,
    input logic [WORD_W-1:0]        out_idx,
    input logic [LANES*SEL_W-1:0]   out_sel,
    input logic [LANES-1:0]         out_oor
);

    p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_valid_drops_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_hold_idx_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_idx) && $stable(out_oor) && $stable(out_sel)));

    p_sel_echo_r8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_sel == $past(in_sel));

    p_fwd_dst_r10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && wr_en && in_subops[15:14] == 2'd0 &&
         in_subops[13:10] == wr_addr && !in_sel[0])
        |=> (out_idx[7:0] == {3'b000, $past(wr_data[4:0])} &&
             out_oor[0] == ($past(wr_data[7:5]) != 3'b000)));

    for (genvar l = 0; l < LANES; l++) begin : g_rng
        p_in_depth_r9: assert property (@(posedge clk) disable iff (rst)
            out_valid |-> ({1'b0, out_idx[l*LANE_W +: LANE_W]} >>
                depth_lg(map_file(l, out_sel[l*SEL_W +: SEL_W]))) == '0);
    end

endmodule

bind idx_calc_unit idx_calc_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_subops (in_subops),
    .in_sel    (in_sel),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .out_valid (out_valid),
    .out_idx   (out_idx),
    .out_sel   (out_sel),
    .out_oor   (out_oor)
);

// File: tb/idx_calc_unit_tb.sv
module idx_calc_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] in_subops = '0;
    logic [7:0]  in_sel = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        out_valid;
    logic [31:0] out_idx;
    logic [7:0]  out_sel;
    logic [3:0]  out_oor;

    always #4 clk = ~clk;

    idx_calc_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_subops(in_subops),
        .in_sel(in_sel), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .out_valid(out_valid), .out_idx(out_idx), .out_sel(out_sel), .out_oor(out_oor)
    );

    int    n_tests = 0;
    int    n_fail  = 0;
    int    cyc     = 0;
    bit    armed   = 0;
    bit    done    = 0;
    int    mreg [16][4];
    bit    e_valid;
    int    e_idx [4];
    bit    e_oor [4];
    logic [7:0] e_sel;
    string e_tag [4];
    bit    e_rst;

    function automatic logic [15:0] mk(input int op, input int ra, input int rb, input int imm);
        return {op[1:0], ra[3:0], rb[3:0], imm[5:0]};
    endfunction

    // behavioural reference model, evaluated at every rising edge
    always @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < 16; r++) for (int l = 0; l < 4; l++) mreg[r][l] = 0;
            e_valid = 0; e_sel = '0; e_rst = 1;
            for (int l = 0; l < 4; l++) begin e_idx[l] = 0; e_oor[l] = 0; e_tag[l] = "R1"; end
        end else begin
            e_rst   = 0;
            e_valid = in_valid;
            if (in_valid) begin
                for (int l = 0; l < 4; l++) begin
                    int op, ra, rb, imm, a, b, full, dep, s;
                    bit fwd;
                    op  = int'(in_subops[16*l+14 +: 2]);
                    ra  = int'(in_subops[16*l+10 +: 4]);
                    rb  = int'(in_subops[16*l+6 +: 4]);
                    imm = int'(in_subops[16*l +: 6]);
                    a = (wr_en && int'(wr_addr) == ra) ? int'(wr_data[8*l +: 8]) : mreg[ra][l];
                    b = (wr_en && int'(wr_addr) == rb) ? int'(wr_data[8*l +: 8]) : mreg[rb][l];
                    fwd = wr_en && (int'(wr_addr) == ra || (op >= 2 && int'(wr_addr) == rb));
                    case (op)
                        0: full = a;
                        1: full = a + imm;
                        2: full = a + b;
                        default: full = a * b + imm;
                    endcase
                    s = int'(in_sel[2*l +: 2]);
                    if (l == 0) dep = ((s & 1) != 0) ? 16 : 32;
                    else dep = (s == 0) ? 32 : (s == 1) ? 32 : 256;
                    e_idx[l] = full % dep;
                    e_oor[l] = (full >= dep);
                    if (fwd)           e_tag[l] = "R10";
                    else if (e_oor[l]) e_tag[l] = "R9";
                    else case (op)
                        0: e_tag[l] = "R3";
                        1: e_tag[l] = "R4";
                        2: e_tag[l] = "R5";
                        default: e_tag[l] = "R6";
                    endcase
                end
                e_sel = in_sel;
            end
            if (wr_en) for (int l = 0; l < 4; l++) mreg[wr_addr][l] = int'(wr_data[8*l +: 8]);
        end
        armed = 1;
    end

    // compare away from the rising edge
    always @(negedge clk) begin
        if (armed && !done) begin
            n_tests++;
            if (out_valid !== e_valid) begin
                n_fail++;
                $display("FAIL %s valid: actual %0b expected %0b", e_rst ? "R1" : "R2", out_valid, e_valid);
            end
            n_tests++;
            if (out_sel !== e_sel) begin
                n_fail++;
                $display("FAIL %s sel: actual %h expected %h", e_rst ? "R1" : "R8", out_sel, e_sel);
            end
            for (int l = 0; l < 4; l++) begin
                n_tests++;
                if (int'(out_idx[8*l +: 8]) != e_idx[l] || out_oor[l] !== e_oor[l]) begin
                    n_fail++;
                    $display("FAIL %s lane %0d (R7 data path): actual idx %0d oor %0b expected idx %0d oor %0b",
                             e_tag[l], l, out_idx[8*l +: 8], out_oor[l], e_idx[l], e_oor[l]);
                end
            end
        end
    end

    task automatic step(input bit v, input logic [63:0] so, input logic [7:0] sl,
                        input bit we, input int wa, input logic [31:0] wd);
        @(negedge clk);
        in_valid = v; in_subops = so; in_sel = sl;
        wr_en = we; wr_addr = wa[3:0]; wr_data = wd;
    endtask

    task automatic wr(input int wa, input logic [31:0] wd);
        step(0, in_subops, in_sel, 1, wa, wd);
    endtask

    task automatic ins(input logic [63:0] so, input logic [7:0] sl);
        step(1, so, sl, 0, 0, 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;                                   // R1 checked during reset cycles
        // R7: fill registers with distinct per-lane bytes
        wr(1, 32'h04_03_02_01);
        wr(2, 32'h28_1E_14_0A);
        wr(3, 32'hFF_C8_11_05);
        wr(4, 32'h0F_10_1F_0F);
        // R3: pass, each lane its own byte
        ins({mk(0,1,0,0), mk(0,2,0,0), mk(0,3,0,0), mk(0,2,0,0)}, 8'b10_01_00_00);
        step(0, '0, '0, 0, 0, 0);                  // R2 hold
        // R4: add immediate, dst 10+6=16 into output file boundary (R9)
        ins({mk(1,3,0,1), mk(1,2,0,63), mk(1,1,0,5), mk(1,2,0,6)}, 8'b10_01_00_01);
        // R4/R9: dst 15 fits output file, lane3 255+1 wraps in constant memory
        ins({mk(1,3,0,1), mk(1,4,0,0), mk(1,2,0,2), mk(1,4,0,0)}, 8'b11_00_01_01);
        // R5: register adds, crossing 32 in general file
        ins({mk(2,2,1,0), mk(2,4,4,0), mk(2,3,2,0), mk(2,1,2,0)}, 8'b10_00_01_00);
        // R6: multiply-add exact, product beyond 8 bits
        ins({mk(3,3,3,63), mk(3,2,1,1), mk(3,1,1,3), mk(3,1,2,0)}, 8'b10_10_01_00);
        // R8: lane 0 code bit 1 ignored
        ins({mk(0,3,0,0), mk(0,3,0,0), mk(0,3,0,0), mk(0,4,0,0)}, 8'b00_00_00_10);
        ins({mk(0,3,0,0), mk(0,3,0,0), mk(0,3,0,0), mk(0,4,0,0)}, 8'b00_00_00_11);
        // R10: loop counter in r0 stepped and used in the same cycle
        for (int i = 0; i < 40; i++) begin
            step(1, {mk(1,0,0,3), mk(1,0,0,2), mk(1,0,0,1), mk(1,0,0,4)}, 8'b10_01_00_01,
                 1, 0, {i[7:0], i[7:0], i[7:0], i[7:0]});
        end
        // random mix of instructions and writes
        for (int k = 0; k < 600; k++) begin
            logic [63:0] so;
            so = {$urandom, $urandom};
            step($urandom_range(0, 3) != 0, so, 8'($urandom), $urandom_range(0, 1) == 1,
                 $urandom_range(0, 15), $urandom);
        end
        step(0, '0, '0, 0, 0, 0);
        step(0, '0, '0, 0, 0, 0);
        @(negedge clk);
        @(posedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule